// File: doc/BRIEF.md
# Multiply-Accumulate Coprocessor

This unit sits beside a small processor core and performs 32x32-bit unsigned multiplies, optionally summing the products into a 64-bit accumulator. The processor reaches it through a register-transfer port. A transfer names a starting register index and a length in words. The unit exposes a window of five registers at indices 25 to 29: the control word, the low and high halves of the product, and the two captured operands. The processor supplies its live operand registers on two dedicated inputs.

The unit has two modes. In plain-multiply mode it captures both live operands on every clock edge and updates the 64-bit product on the same edge. In accumulate mode the operands are captured only when a write reaches the control word with the mode bit set. Each such write performs one step: the new product is added to the accumulator, and a wrap raises a sticky carry flag. Writing 1 to the carry bit clears the flag and empties the accumulator.

Top module: `mac_copro`

## Requirements
- R1: After synchronous reset, the control word, product, operands and accumulator are zero, the unit is in plain-multiply mode, and `xfer_err` and `xfer_rdata` are zero.
- R2: A valid read returns its words on `xfer_rdata` on the cycle after the request. Word k sits in bits [32k+31:32k] and holds register index start+k, and words at k >= length are zero. The registers read as follows: index 25 is the control word (bit 0 mode, bit 1 carry, other bits zero), 26 is the product low, 27 the product high, 28 operand 0 and 29 operand 1. A read returns the state from before its own clock edge. With no read request, all words are zero.
- R3: In plain-multiply mode (mode bit 0), operand 0 and operand 1 take `live_op0` and `live_op1` on every clock edge.
- R4: In plain-multiply mode, the product takes the full 64-bit unsigned product of the live operands on the same edge, and the accumulator is forced to zero.
- R5: A valid write touches the control word only if it starts at index 25, and then bit 0 of `xfer_wdata` sets the mode. Writes starting at indices 26 to 29 change no state.
- R6: A valid control-word write with bit 0 = 1 performs one accumulate step. It captures the live operands and computes sum = accumulator + op0*op1 modulo 2^64. The sum is stored in both the product and the accumulator.
- R7: In accumulate mode, with no control-word write, the operands, product and accumulator hold their values.
- R8: An accumulate step whose sum is below the previous accumulator sets the carry bit. The carry bit stays set until it is cleared.
- R9: A control-word write with bit 1 = 1 clears the carry and zeroes the accumulator. The clear takes effect after a step on the same edge, so that step's carry and accumulator are discarded while its product is kept.
- R10: A request is out of range when the start is below 25, the length is 0, or start+length exceeds 30. Such a request raises `xfer_err` on the next cycle, changes no state and reads as all zeros.
- R11: `xfer_err` is low on the cycle after a cycle with no request or with only valid requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_wr | input | 1 | Write strobe for a transfer |
| xfer_rd | input | 1 | Read request for a transfer |
| xfer_idx | input | 5 | Starting register index |
| xfer_len | input | 3 | Transfer length in 32-bit words |
| xfer_wdata | input | 32 | Word written to the starting register |
| live_op0 | input | 32 | Processor's current first operand |
| live_op1 | input | 32 | Processor's current second operand |
| xfer_rdata | output | 160 | Read words, word k at bits [32k+31:32k] |
| xfer_err | output | 1 | Out-of-range flag for the previous request |

## Verification
The bound checker watches several behaviours on every cycle. It checks operand capture and accumulator zeroing in plain-multiply mode, and that state holds in accumulate mode while no control write arrives. It also checks that the carry stays sticky, that a clear empties the accumulator, that the error flag follows a request below the window, and that read data is zero when no read was made. The arithmetic itself can only be shown by the bench's scenarios: the 64-bit sum and its wrap, and the ordering of a step against a clear on the same edge. The same holds for the read word placement and for proving that ignored and out-of-range writes leave state alone. The bench shows these with directed sequences and with a reference model fed by random transfers.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int WIN_BASE  = 25;
  localparam int WIN_WORDS = 5;
  localparam int CTL_MODE  = 0;
  localparam int CTL_CARRY = 1;
  localparam int SLOT_CTL  = 0;
  localparam int SLOT_PLO  = 1;
  localparam int SLOT_PHI  = 2;
  localparam int SLOT_OP0  = 3;
  localparam int SLOT_OP1  = 4;
endpackage

// File: rtl/mac_win_dec.sv
module mac_win_dec #(
  parameter int IDX_W = 5,
  parameter int LEN_W = 3
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [LEN_W-1:0] len,
  output logic             in_range,
  output logic [IDX_W-1:0] slot_off,
  output logic             hits_ctl
);
  import mac_pkg::*;
  localparam int LAST_END = WIN_BASE + WIN_WORDS;

  always_comb begin
    in_range = (int'(idx) >= WIN_BASE) && (len != '0) &&
               ((int'(idx) + int'(len)) <= LAST_END);
    slot_off = idx - IDX_W'(WIN_BASE);
    hits_ctl = in_range && (int'(idx) == WIN_BASE);
  end
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] live_a,
  input  logic [DW-1:0] live_b,
  input  logic          ctl_wr,
  input  logic          ctl_mode_bit,
  input  logic          ctl_clr_bit,
  output logic          mode_q,
  output logic          carry_q,
  output logic [DW-1:0] op0_q,
  output logic [DW-1:0] op1_q,
  output logic [2*DW-1:0] prod_q,
  output logic [2*DW-1:0] acc_q
);
  logic [2*DW-1:0] live_prod;
  logic [2*DW-1:0] step_sum;

  always_comb begin
    live_prod = {{DW{1'b0}}, live_a} * {{DW{1'b0}}, live_b};
    step_sum  = acc_q + live_prod;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= 1'b0;
      carry_q <= 1'b0;
      op0_q   <= '0;
      op1_q   <= '0;
      prod_q  <= '0;
      acc_q   <= '0;
    end else begin
      if (!mode_q) begin
        op0_q  <= live_a;
        op1_q  <= live_b;
        prod_q <= live_prod;
        acc_q  <= '0;
      end
      if (ctl_wr) begin
        mode_q <= ctl_mode_bit;
        if (ctl_mode_bit) begin
          op0_q  <= live_a;
          op1_q  <= live_b;
          prod_q <= step_sum;
          acc_q  <= step_sum;
          if (step_sum < acc_q) carry_q <= 1'b1;
        end
        if (ctl_clr_bit) begin
          carry_q <= 1'b0;
          acc_q   <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/mac_readback.sv
module mac_readback #(
  parameter int DW    = 32,
  parameter int NW    = 5,
  parameter int IDX_W = 5,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_go,
  input  logic [IDX_W-1:0] slot_off,
  input  logic [LEN_W-1:0] len,
  input  logic [DW-1:0]    slots [NW],
  output logic [NW*DW-1:0] rdata
);
  logic [NW*DW-1:0] pick;

  for (genvar k = 0; k < NW; k++) begin : g_word
    always_comb begin
      pick[k*DW +: DW] = '0;
      if ((k < int'(len)) && ((int'(slot_off) + k) < NW))
        pick[k*DW +: DW] = slots[int'(slot_off) + k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_go ? pick : '0;
  end
endmodule

// File: rtl/mac_copro.sv
module mac_copro #(
  parameter int DW    = 32,
  parameter int IDX_W = 5,
  parameter int LEN_W = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 xfer_wr,
  input  logic                 xfer_rd,
  input  logic [IDX_W-1:0]     xfer_idx,
  input  logic [LEN_W-1:0]     xfer_len,
  input  logic [DW-1:0]        xfer_wdata,
  input  logic [DW-1:0]        live_op0,
  input  logic [DW-1:0]        live_op1,
  output logic [mac_pkg::WIN_WORDS*DW-1:0] xfer_rdata,
  output logic                 xfer_err
);
  import mac_pkg::*;
  localparam int NW = WIN_WORDS;

  logic             in_range, hits_ctl;
  logic [IDX_W-1:0] slot_off;
  logic             ctl_wr, ctl_mode_bit, ctl_clr_bit;
  logic             mode_q, carry_q;
  logic [DW-1:0]    op0_q, op1_q;
  logic [2*DW-1:0]  prod_q, acc_q;
  logic [DW-1:0]    slots [NW];
  logic             unused_wbits;

  mac_win_dec #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_dec (
    .idx(xfer_idx), .len(xfer_len),
    .in_range(in_range), .slot_off(slot_off), .hits_ctl(hits_ctl)
  );

  assign ctl_wr       = xfer_wr && hits_ctl;
  assign ctl_mode_bit = xfer_wdata[CTL_MODE];
  assign ctl_clr_bit  = xfer_wdata[CTL_CARRY];
  assign unused_wbits = ^xfer_wdata[DW-1:2];

  mac_datapath #(.DW(DW)) u_dp (
    .clk(clk), .rst(rst), .live_a(live_op0), .live_b(live_op1),
    .ctl_wr(ctl_wr), .ctl_mode_bit(ctl_mode_bit), .ctl_clr_bit(ctl_clr_bit),
    .mode_q(mode_q), .carry_q(carry_q), .op0_q(op0_q), .op1_q(op1_q),
    .prod_q(prod_q), .acc_q(acc_q)
  );

  always_comb begin
    slots[SLOT_CTL] = '0;
    slots[SLOT_CTL][CTL_MODE]  = mode_q;
    slots[SLOT_CTL][CTL_CARRY] = carry_q;
    slots[SLOT_PLO] = prod_q[DW-1:0];
    slots[SLOT_PHI] = prod_q[2*DW-1:DW];
    slots[SLOT_OP0] = op0_q;
    slots[SLOT_OP1] = op1_q;
  end

  mac_readback #(.DW(DW), .NW(NW), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_rb (
    .clk(clk), .rst(rst), .rd_go(xfer_rd && in_range),
    .slot_off(slot_off), .len(xfer_len), .slots(slots), .rdata(xfer_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) xfer_err <= 1'b0;
    else     xfer_err <= (xfer_wr || xfer_rd) && !in_range;
  end
endmodule

// File: rtl/mac_copro_chk.sv
module mac_copro_chk #(
  parameter int DW    = 32,
  parameter int IDX_W = 5,
  parameter int NW    = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             xfer_wr,
  input logic             xfer_rd,
  input logic [IDX_W-1:0] xfer_idx,
  input logic [NW*DW-1:0] xfer_rdata,
  input logic             xfer_err,
  input logic [DW-1:0]    live_op0,
  input logic [DW-1:0]    live_op1,
  input logic             ctl_wr,
  input logic             ctl_mode_bit,
  input logic             ctl_clr_bit,
  input logic             mode_q,
  input logic             carry_q,
  input logic [DW-1:0]    op0_q,
  input logic [DW-1:0]    op1_q,
  input logic [2*DW-1:0]  prod_q,
  input logic [2*DW-1:0]  acc_q
);
  p_idle_rdata_r2: assert property (@(posedge clk) disable iff (rst)
    !xfer_rd |=> xfer_rdata == '0);

  p_capture_r3: assert property (@(posedge clk) disable iff (rst)
    !mode_q |=> (op0_q == $past(live_op0)) && (op1_q == $past(live_op1)));

  p_acc_zero_r4: assert property (@(posedge clk) disable iff (rst)
    !mode_q && !(ctl_wr && ctl_mode_bit) |=> acc_q == '0);

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    mode_q && !ctl_wr |=> $stable(prod_q) && $stable(acc_q) && $stable(op0_q) && $stable(op1_q));

  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    carry_q && !(ctl_wr && ctl_clr_bit) |=> carry_q);

  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    ctl_wr && ctl_clr_bit |=> !carry_q && (acc_q == '0));

  p_low_idx_r10: assert property (@(posedge clk) disable iff (rst)
    (xfer_wr || xfer_rd) && (int'(xfer_idx) < 25) |=> xfer_err);

  p_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !(xfer_wr || xfer_rd) |=> !xfer_err);
endmodule

bind mac_copro mac_copro_chk #(.DW(DW), .IDX_W(IDX_W), .NW(mac_pkg::WIN_WORDS)) u_chk (
  .clk(clk), .rst(rst), .xfer_wr(xfer_wr), .xfer_rd(xfer_rd), .xfer_idx(xfer_idx),
  .xfer_rdata(xfer_rdata), .xfer_err(xfer_err), .live_op0(live_op0), .live_op1(live_op1),
  .ctl_wr(ctl_wr), .ctl_mode_bit(ctl_mode_bit), .ctl_clr_bit(ctl_clr_bit),
  .mode_q(mode_q), .carry_q(carry_q), .op0_q(op0_q), .op1_q(op1_q),
  .prod_q(prod_q), .acc_q(acc_q)
);

// File: tb/sim_mac_copro.sv
`timescale 1ns/1ps
module sim_mac_copro;
  localparam int DW = 32;
  localparam int NW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic xfer_wr = 0, xfer_rd = 0;
  logic [4:0] xfer_idx = '0;
  logic [2:0] xfer_len = '0;
  logic [DW-1:0] xfer_wdata = '0, live_op0 = '0, live_op1 = '0;
  logic [NW*DW-1:0] xfer_rdata;
  logic xfer_err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  bit m_mode, m_carry;
  logic [DW-1:0] m_op0, m_op1;
  logic [2*DW-1:0] m_prod, m_acc;

  always #4 clk = ~clk;

  mac_copro u0 (
    .clk(clk), .rst(rst), .xfer_wr(xfer_wr), .xfer_rd(xfer_rd), .xfer_idx(xfer_idx),
    .xfer_len(xfer_len), .xfer_wdata(xfer_wdata), .live_op0(live_op0), .live_op1(live_op1),
    .xfer_rdata(xfer_rdata), .xfer_err(xfer_err)
  );

  function automatic bit ok_range(input logic [4:0] idx, input logic [2:0] len);
    return (int'(idx) >= 25) && (len != 0) && (int'(idx) + int'(len) <= 30);
  endfunction

  function automatic logic [DW-1:0] reg_word(input int slot);
    case (slot)
      0: return {30'd0, m_carry, m_mode};
      1: return m_prod[DW-1:0];
      2: return m_prod[2*DW-1:DW];
      3: return m_op0;
      default: return m_op1;
    endcase
  endfunction

  function automatic logic [NW*DW-1:0] model_read(input logic [4:0] idx, input logic [2:0] len);
    logic [NW*DW-1:0] v = '0;
    for (int k = 0; k < NW; k++)
      if (k < int'(len)) v[k*DW +: DW] = reg_word(int'(idx) - 25 + k);
    return v;
  endfunction

  task automatic check_bit(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_vec(input string tag, input logic [NW*DW-1:0] act, input logic [NW*DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input bit wr, input bit rd, input logic [4:0] idx, input logic [2:0] len,
                      input logic [DW-1:0] wd, input logic [DW-1:0] a, input logic [DW-1:0] b,
                      input string tag);
    bit v;
    logic [NW*DW-1:0] exp_rd;
    bit exp_err;
    logic [2*DW-1:0] p, old_acc, sum;
    xfer_wr = wr; xfer_rd = rd; xfer_idx = idx; xfer_len = len;
    xfer_wdata = wd; live_op0 = a; live_op1 = b;
    v = ok_range(idx, len);
    exp_rd  = (rd && v) ? model_read(idx, len) : '0;
    exp_err = (wr || rd) && !v;
    @(posedge clk);
    p = {32'd0, a} * {32'd0, b};
    old_acc = m_acc;
    if (!m_mode) begin
      m_op0 = a; m_op1 = b; m_prod = p; m_acc = '0;
    end
    if (wr && v && idx == 5'd25) begin
      m_mode = wd[0];
      if (wd[0]) begin
        sum = old_acc + p;
        m_op0 = a; m_op1 = b; m_prod = sum; m_acc = sum;
        if (sum < old_acc) m_carry = 1;
      end
      if (wd[1]) begin
        m_carry = 0; m_acc = '0;
      end
    end
    @(negedge clk);
    xfer_wr = 0; xfer_rd = 0;
    check_bit({tag, " err R10/R11"}, xfer_err, exp_err);
    check_vec({tag, " rdata R2"}, xfer_rdata, exp_rd);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: all requirements, actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    process::self().srandom(32'd7);
    m_mode = 0; m_carry = 0; m_op0 = '0; m_op1 = '0; m_prod = '0; m_acc = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    check_bit("R1 err after reset", xfer_err, 1'b0);
    check_vec("R1 rdata after reset", xfer_rdata, '0);
    step(0, 1, 25, 5, 0, 0, 0, "R1");

    step(0, 0, 0, 0, 0, 7, 9, "R3");
    step(0, 1, 25, 5, 0, 11, 13, "R4");
    step(0, 1, 28, 2, 0, 32'hFFFF_FFFF, 32'h8000_0001, "R3");
    step(0, 1, 26, 2, 0, 0, 0, "R4");

    step(1, 0, 25, 1, 32'h1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6");
    step(0, 1, 25, 5, 0, 5, 6, "R6");
    step(0, 0, 0, 0, 0, 99, 98, "R7");
    step(0, 1, 25, 5, 0, 17, 3, "R7");

    step(1, 0, 25, 1, 32'h1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R8");
    step(0, 1, 25, 5, 0, 0, 0, "R8");
    step(1, 0, 25, 2, 32'h1, 0, 0, "R8");
    step(0, 1, 25, 1, 0, 0, 0, "R8");

    step(1, 0, 26, 4, 32'hFFFF_FFFF, 123, 456, "R5");
    step(1, 0, 29, 1, 32'h3, 1, 1, "R5");
    step(0, 1, 25, 5, 0, 0, 0, "R5");

    step(1, 0, 25, 1, 32'h3, 2, 3, "R9");
    step(0, 1, 25, 5, 0, 0, 0, "R9");
    step(1, 0, 25, 1, 32'h1, 1, 1, "R9");
    step(0, 1, 26, 2, 0, 0, 0, "R9");

    step(1, 0, 24, 2, 32'h2, 4, 4, "R10");
    step(0, 1, 29, 2, 0, 0, 0, "R10");
    step(1, 1, 25, 0, 32'h2, 0, 0, "R10");
    step(1, 0, 25, 6, 32'h0, 0, 0, "R10");
    step(0, 1, 25, 5, 0, 0, 0, "R10");

    step(1, 0, 25, 1, 32'h0, 8, 8, "R5");
    step(0, 1, 25, 5, 0, 21, 2, "R11");

    for (int i = 0; i < 4000; i++) begin
      bit wr = ($urandom % 3) == 0;
      bit rd = ($urandom % 2) == 0;
      logic [4:0] idx = 5'(23 + ($urandom % 8));
      logic [2:0] len = 3'($urandom % 7);
      logic [DW-1:0] wd = {$urandom} & 32'hFFFF_FFFD;
      logic [DW-1:0] a = ($urandom % 4 == 0) ? 32'hFFFF_FFFF - ($urandom % 16) : $urandom;
      logic [DW-1:0] b = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom;
      if ($urandom % 4 == 0) wd[1] = 1'b1;
      if ($urandom % 3 != 0 && wr) begin idx = 25; len = 3'(1 + $urandom % 5); end
      step(wr, rd, idx, len, wd, a, b, "R6/R8 random");
    end

    done = 1;
    summary();
  end
endmodule